// File: doc/BRIEF.md
# Block-Move DMA Engine with Bus Hold Handshake

This block copies a run of words between a peripheral data port and a RAM with no processor involvement in each word. Software loads a start address and a word count into the engine's configuration registers. It then writes the control register with the go bit set, which also latches the transfer direction. The engine asks the processor for the memory bus by raising a hold request. It touches the bus only after the processor answers with hold acknowledge. From then on it moves one word per memory cycle, either from the peripheral into RAM or from RAM out to the peripheral.

The peripheral sets the pace with a request/acknowledge pair. A word moves only in a cycle where the peripheral request is high while the engine owns the bus. After each word the engine steps its working address up by one and its remaining count down by one. When the count runs out it drops hold, releases the bus outputs and raises a sticky completion flag. An interrupt line can follow that flag. A go with a count of zero completes at once and never asks for the bus.

Top module: `blkmove_dma`

## Requirements
- R1: Configuration writes are selected by `cfg_sel`: 0 loads the start address, 1 loads the word count, 2 writes control. The control bits are bit 0 go, bit 1 direction, bit 2 clear-done and bit 3 interrupt enable. Address and count writes, and go, are ignored while a transfer is in progress. The interrupt enable bit is updated on every control write.
- R2: A go with a nonzero count raises `hold_o` in the next cycle. `hold_o` then stays high until the last word. `bus_oe_o`, both strobes and the address stay low until `hold_ack_i` has been sampled high at a clock edge. `bus_oe_o` rises in the cycle after that edge.
- R3: Each word moves in a single cycle with one strobe, with no register in the data path. On a memory write, `mem_wdata_o` equals `per_rdata_i`. On a memory read, `per_wdata_o` equals `mem_rdata_i` in the same cycle.
- R4: Direction 0 moves peripheral to memory using `mem_wr_o`. Direction 1 moves memory to peripheral using `mem_rd_o`. The two strobes are never high together.
- R5: The first word uses the loaded start address. Each later word uses the previous address plus one, wrapping modulo 2^ADDR_W.
- R6: Exactly count words move. In the cycle after the last word, `hold_o` and `bus_oe_o` are low and `done_o` is high.
- R7: In a cycle where the engine owns the bus and `per_req_i` is low, no strobe and no `per_ack_o` are given, and the address and count hold. `per_ack_o` is high exactly in the cycles where a word moves.
- R8: A go with a count of zero sets `done_o` in the next cycle and never raises `hold_o`.
- R9: `done_o` stays set until a control write with clear-done, or until an accepted go with a nonzero count. `irq_o` equals `done_o` AND the interrupt enable bit.
- R10: Outside the owned window, `bus_oe_o`, `mem_rd_o`, `mem_wr_o`, `mem_addr_o` and `mem_wdata_o` are all zero. This is also the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | CFG_W | Configuration write data |
| hold_o | output | 1 | Bus hold request to the processor |
| hold_ack_i | input | 1 | Hold acknowledge from the processor |
| bus_oe_o | output | 1 | Enable for the bus output buffers |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data |
| per_req_i | input | 1 | Peripheral ready for a word |
| per_ack_o | output | 1 | Word taken from or given to the peripheral |
| per_rdata_i | input | DATA_W | Data from the peripheral |
| per_wdata_o | output | DATA_W | Data to the peripheral |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench varies the hold-acknowledge latency. An engine that drove the bus on its own request, before the grant, would show a nonzero enable or strobe while the reference still waits. It throttles the peripheral request in several patterns. Here an engine that counted idle cycles as words would end early and skip addresses. It starts one run two words below the top of memory, where a missing wrap shows up as a wrong address, and it issues a zero-count go, where an engine that asked for the bus anyway would raise hold. Writes and a second go are issued mid-transfer to show that an engine which accepted them would restart or jump to a new address. The clear-done and interrupt-enable combinations expose a completion flag that is not sticky or an interrupt that ignores the enable.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_OWN  = 2'd2
  } xfer_state_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CB_GO  = 0;
  localparam int CB_DIR = 1;
  localparam int CB_CLR = 2;
  localparam int CB_IE  = 3;
  localparam int CTRL_BITS = 4;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  input  logic              finish,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  base_cnt,
  output logic              launch,
  output logic              launch_dir,
  output logic              done,
  output logic              irq_en
);
  logic ctrl_wr, go_acc, clr_req, zero_done;

  function automatic logic cnt_is_zero(input logic [CNT_W-1:0] c);
    return c == '0;
  endfunction

  assign ctrl_wr    = cfg_we && (cfg_sel == SEL_CTRL);
  assign go_acc     = ctrl_wr && cfg_wdata[CB_GO] && !busy;
  assign clr_req    = ctrl_wr && cfg_wdata[CB_CLR];
  assign zero_done  = go_acc && cnt_is_zero(base_cnt);
  assign launch     = go_acc && !cnt_is_zero(base_cnt);
  assign launch_dir = cfg_wdata[CB_DIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      irq_en    <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_ADDR && !busy) base_addr <= cfg_wdata[ADDR_W-1:0];
      if (cfg_sel == SEL_CNT && !busy)  base_cnt  <= cfg_wdata[CNT_W-1:0];
      if (cfg_sel == SEL_CTRL)          irq_en    <= cfg_wdata[CB_IE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done <= 1'b0;
    else if (finish || zero_done) done <= 1'b1;
    else if (clr_req || launch)   done <= 1'b0;
  end

  // R8
  zero_go_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> done);
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_req && !launch |=> done);
  // R1
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_dir,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  base_cnt,
  input  logic              hold_ack_i,
  input  logic              per_req_i,
  output logic              hold,
  output logic              own,
  output logic              fire,
  output logic              finish,
  output logic              dir,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [CNT_W-1:0]  C_ONE = 1;

  xfer_state_t     state;
  logic [CNT_W-1:0] left;

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] a);
    return a + A_ONE;
  endfunction

  function automatic logic [CNT_W-1:0] step_left(input logic [CNT_W-1:0] c);
    return c - C_ONE;
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == C_ONE;
  endfunction

  assign hold   = state != XS_IDLE;
  assign own    = state == XS_OWN;
  assign fire   = own && per_req_i;
  assign finish = fire && is_last(left);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XS_IDLE;
      ptr   <= '0;
      left  <= '0;
      dir   <= 1'b0;
    end else begin
      unique case (state)
        XS_IDLE: if (launch) begin
          state <= XS_WAIT;
          ptr   <= base_addr;
          left  <= base_cnt;
          dir   <= launch_dir;
        end
        XS_WAIT: if (hold_ack_i) state <= XS_OWN;
        XS_OWN: if (per_req_i) begin
          ptr  <= step_ptr(ptr);
          left <= step_left(left);
          if (is_last(left)) state <= XS_IDLE;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  // R2
  grant_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> $past(hold_ack_i));
  // R2
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !finish |=> hold);
  // R6
  left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own |-> left != '0);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !hold && !own);
  // R5
  ptr_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !finish |=> ptr == $past(ptr) + A_ONE);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own && !per_req_i |=> $stable(ptr) && $stable(left));
endmodule

// File: rtl/dma_bus_mux.sv
module dma_bus_mux #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own,
  input  logic              fire,
  input  logic              dir,
  input  logic              per_req_i,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] per_rdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              bus_oe_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              per_ack_o,
  output logic [DATA_W-1:0] per_wdata_o
);
  assign bus_oe_o    = own;
  assign mem_rd_o    = fire && dir;
  assign mem_wr_o    = fire && !dir;
  assign mem_addr_o  = own ? ptr : '0;
  assign mem_wdata_o = mem_wr_o ? per_rdata_i : '0;
  assign per_ack_o   = fire;
  assign per_wdata_o = mem_rd_o ? mem_rdata_i : '0;

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o}));
  // R10
  strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> bus_oe_o);
  // R10
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> mem_addr_o == '0 && mem_wdata_o == '0);
  // R7
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack_o |-> per_req_i && (mem_rd_o || mem_wr_o));
endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  localparam int CFG_W = (ADDR_W > CNT_W ? ADDR_W : CNT_W) > dma_pkg::CTRL_BITS ?
                         (ADDR_W > CNT_W ? ADDR_W : CNT_W) : dma_pkg::CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              hold_o,
  input  logic              hold_ack_i,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              per_req_i,
  output logic              per_ack_o,
  input  logic [DATA_W-1:0] per_rdata_i,
  output logic [DATA_W-1:0] per_wdata_o,
  output logic              done_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] base_addr, ptr;
  logic [CNT_W-1:0]  base_cnt;
  logic launch, launch_dir, done, irq_en;
  logic hold, own, fire, finish, dir;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(hold), .finish(finish),
    .base_addr(base_addr), .base_cnt(base_cnt), .launch(launch),
    .launch_dir(launch_dir), .done(done), .irq_en(irq_en)
  );

  dma_xfer_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_dir(launch_dir),
    .base_addr(base_addr), .base_cnt(base_cnt), .hold_ack_i(hold_ack_i),
    .per_req_i(per_req_i), .hold(hold), .own(own), .fire(fire),
    .finish(finish), .dir(dir), .ptr(ptr)
  );

  dma_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .own(own), .fire(fire), .dir(dir),
    .per_req_i(per_req_i), .ptr(ptr), .per_rdata_i(per_rdata_i),
    .mem_rdata_i(mem_rdata_i), .bus_oe_o(bus_oe_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .per_ack_o(per_ack_o), .per_wdata_o(per_wdata_o)
  );

  assign hold_o = hold;
  assign done_o = done;
  assign irq_o  = done && irq_en;

  // R8
  zero_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && !$past(bus_oe_o) |-> !hold_o);
  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o && !hold_o |-> 1'b0);
endmodule

// File: tb/blkmove_dma_tb.sv
module blkmove_dma_tb_top;
  localparam int CLK_NS = 10;
  localparam int WDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic hold_o, hold_ack_i, bus_oe_o, mem_rd_o, mem_wr_o, per_ack_o, done_o, irq_o;
  logic [7:0] mem_addr_o, mem_wdata_o, mem_rdata_i, per_rdata_i, per_wdata_o;
  logic per_req_i = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  blkmove_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hold_o(hold_o), .hold_ack_i(hold_ack_i), .bus_oe_o(bus_oe_o), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .per_req_i(per_req_i), .per_ack_o(per_ack_o),
    .per_rdata_i(per_rdata_i), .per_wdata_o(per_wdata_o), .done_o(done_o), .irq_o(irq_o)
  );

  // environment: RAM, processor grant with latency, peripheral pacing
  logic [7:0] ram [256];
  assign mem_rdata_i = ram[mem_addr_o];
  int ack_lat = 1;
  int req_mode = 0;
  logic [7:0] hold_hist = '0;
  logic [7:0] tick = 8'h3c;
  assign hold_ack_i = hold_hist[ack_lat];
  assign per_rdata_i = tick ^ 8'h5a;

  always @(posedge clk) begin
    if (mem_wr_o) ram[mem_addr_o] <= mem_wdata_o;
    hold_hist <= {hold_hist[6:0], hold_o};
    #1;
    tick <= tick + 8'd7;
    case (req_mode)
      0: per_req_i <= 1'b1;
      1: per_req_i <= ~per_req_i;
      default: per_req_i <= tick[2] ^ tick[5];
    endcase
  end

  // behavioural reference model
  int m_phase = 0, m_cnt = 0, m_left = 0;
  int m_addr = 0, m_ptr = 0;
  bit m_dir = 0, m_done = 0, m_ie = 0;
  int exp_mem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_left = 0; m_addr = 0; m_ptr = 0;
      m_dir = 0; m_done = 0; m_ie = 0;
    end else begin
      bit busy, finished;
      busy = m_phase != 0;
      finished = 0;
      if (m_phase == 1) begin
        if (hold_ack_i) m_phase = 2;
      end else if (m_phase == 2 && per_req_i) begin
        if (!m_dir) exp_mem[m_ptr] = per_rdata_i;
        m_ptr = (m_ptr + 1) % 256;
        m_left--;
        if (m_left == 0) begin m_phase = 0; finished = 1; end
      end
      if (cfg_we) begin
        if (cfg_sel == 0 && !busy) m_addr = cfg_wdata;
        if (cfg_sel == 1 && !busy) m_cnt = cfg_wdata;
        if (cfg_sel == 2) begin
          m_ie = cfg_wdata[3];
          if (cfg_wdata[2]) m_done = 0;
          if (cfg_wdata[0] && !busy) begin
            if (m_cnt == 0) m_done = 1;
            else begin
              m_done = 0; m_phase = 1; m_ptr = m_addr; m_left = m_cnt; m_dir = cfg_wdata[1];
            end
          end
        end
      end
      if (finished) m_done = 1;
    end
  end

  int vectors = 0, fails = 0;
  bit finished_run = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  int hold_cycles = 0;
  bit first_pending = 0;
  int first_addr = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      bit own, f;
      own = m_phase == 2;
      f = own && per_req_i;
      if (hold_o) hold_cycles++;
      if (first_pending && (mem_rd_o || mem_wr_o)) begin
        first_addr = mem_addr_o; first_pending = 0;
      end
      check("R2", "hold_o", hold_o, m_phase != 0);
      check("R10", "bus_oe_o", bus_oe_o, own);
      check("R4", "mem_rd_o", mem_rd_o, f && m_dir);
      check("R4", "mem_wr_o", mem_wr_o, f && !m_dir);
      check("R5", "mem_addr_o", mem_addr_o, own ? m_ptr : 0);
      check("R3", "mem_wdata_o", mem_wdata_o, (f && !m_dir) ? per_rdata_i : 0);
      check("R7", "per_ack_o", per_ack_o, f);
      check("R3", "per_wdata_o", per_wdata_o, (f && m_dir) ? ram[m_ptr] : 0);
      check("R6", "done_o", done_o, m_done);
      check("R9", "irq_o", irq_o, m_done && m_ie);
    end
  end

  task automatic summary();
    if (!finished_run) begin
      finished_run = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    check("WDOG", "watchdog", 1, 0);
    summary();
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int g = 0;
    while (!done_o && g < 3000) begin @(posedge clk); #1; g++; end
    check(req, "completion reached", done_o, 1);
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic go(input logic [7:0] a, input logic [7:0] n, input bit d, input bit ie);
    wr(2'd0, a);
    wr(2'd1, n);
    first_pending = 1;
    wr(2'd2, {4'b0, ie, 1'b0, d, 1'b1});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i * 3 + 1);
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    // R10 reset state
    check("R10", "reset bus_oe_o", bus_oe_o, 0);
    check("R2", "reset hold_o", hold_o, 0);
    check("R9", "reset done_o", done_o, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R4 R2: peripheral to memory, slow grant, steady requests
    ack_lat = 4; req_mode = 0;
    go(8'h10, 8'd4, 1'b0, 1'b0);
    wait_done("R6");
    check("R1", "first address of run", first_addr, 'h10);

    // R7: memory to peripheral with throttled requests
    ack_lat = 1; req_mode = 1;
    go(8'h10, 8'd5, 1'b1, 1'b0);
    wait_done("R7");

    // R5: wrap at the top of memory, irregular pacing
    ack_lat = 2; req_mode = 2;
    go(8'hFE, 8'd5, 1'b0, 1'b1);
    wait_done("R5");
    check("R9", "irq with enable", irq_o, 1);

    // R9: clear-done with enable kept
    wr(2'd2, 8'b0000_1100);
    @(negedge clk);
    check("R9", "done after clear", done_o, 0);
    check("R9", "irq after clear", irq_o, 0);
    @(posedge clk); #1;

    // R8: zero count, hold never raised
    hold_cycles = 0;
    go(8'h20, 8'd0, 1'b0, 1'b0);
    @(negedge clk);
    check("R8", "done after zero go", done_o, 1);
    repeat (4) @(posedge clk); #1;
    check("R8", "hold cycles on zero go", hold_cycles, 0);

    // R1: writes and go while busy are ignored
    ack_lat = 3; req_mode = 1;
    go(8'h30, 8'd6, 1'b0, 1'b0);
    wr(2'd0, 8'h40);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'b0000_0011);
    wait_done("R1");
    first_pending = 1;
    wr(2'd2, 8'b0000_0011);
    wait_done("R1");
    check("R1", "restart uses retained address", first_addr, 'h30);

    // R3: RAM holds what the peripheral delivered
    foreach (exp_mem[a]) check("R3", "ram content", ram[a], exp_mem[a]);

    summary();
  end
endmodule